// File: doc/BRIEF.md
# L2 Outstanding Miss Tracker

This block records requests that the second-level cache has sent to the third level and has not yet had filled. It has a fixed number of tracking slots. A slot is taken by every demand request that misses in L2 and by every prefetch that is meant to land in L2. Requests that hit in L2 take no slot. Neither do prefetches that are meant to land only in L3. A new miss to a line that already owns a slot joins that slot and takes no second one.

A returning fill names a line address. The slot holding that address is released, and the fill acknowledgement reports whether the line was still marked as a prefetch. When a demand miss joins a prefetch slot, the slot is marked as demand. When every slot is in use, any further request that would need a new slot is answered with a stall and changes nothing, so the requester must retry it later. The count of occupied slots and a full flag are registered outputs that a prefetcher can read.

Every request and every fill is answered one clock later by a registered response.

Top module: `l2_miss_tracker`

## Requirements
- R1: While reset is high and in the first cycle after it, occupancy is 0, full is 0, rsp_valid is 0 and fill_ack_valid is 0.
- R2: A demand request with req_hit=0 and req_pf=0, to a line with no slot and while full=0, gets rsp_kind=2 (allocate) one cycle later, and occupancy rises by one.
- R3: A request with req_hit=1 gets rsp_kind=0 (hit) and takes no slot.
- R4: A prefetch with req_hit=0, req_pf=1 and req_pf_l3=1 gets rsp_kind=1 (bypass) and takes no slot, even when its line already has a slot.
- R5: A prefetch with req_pf=1 and req_pf_l3=0 that misses takes a slot exactly as a demand miss does (rsp_kind=2).
- R6: A slot-needing request whose line already owns a slot gets rsp_kind=3 (merge) and leaves occupancy unchanged.
- R7: While full=1, a request that would need a new slot gets rsp_kind=4 (stall) and has no effect. Merges and hits are still answered normally. A release in the same cycle does not make room for that request.
- R8: A fill whose address matches a slot gives fill_ack_valid=1 and fill_ack_hit=1 one cycle later, lowers occupancy by one, and sets fill_ack_pf to the slot's prefetch flag (1 = prefetch).
- R9: A fill whose address matches no slot gives fill_ack_valid=1 and fill_ack_hit=0, and occupancy does not change.
- R10: An allocation and a release in the same cycle leave occupancy unchanged.
- R11: A demand miss that merges into a prefetch slot clears the slot's prefetch flag, so the later fill reports fill_ack_pf=0.
- R12: occupancy never exceeds ENTRIES, and full is 1 exactly when occupancy equals ENTRIES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An L2 lookup result is presented |
| req_addr | input | ADDR_W | Line address of the request |
| req_hit | input | 1 | The lookup hit in L2 |
| req_pf | input | 1 | The request is a prefetch |
| req_pf_l3 | input | 1 | The prefetch targets L3 only |
| fill_valid | input | 1 | A fill returns from L3 |
| fill_addr | input | ADDR_W | Line address of the fill |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_kind | output | 3 | 0 hit, 1 bypass, 2 allocate, 3 merge, 4 stall |
| occupancy | output | $clog2(ENTRIES+1) | Occupied slots |
| full | output | 1 | All slots occupied |
| fill_ack_valid | output | 1 | Acknowledgement for last cycle's fill |
| fill_ack_hit | output | 1 | The fill released a slot |
| fill_ack_pf | output | 1 | The released slot was a prefetch |

## Verification
The checks assume that a fill never carries the address of a request presented in the same cycle. A request and a fill to one line in one cycle would have an undefined merge-versus-release order. The checks also assume that every input is held low during reset. The stimulus respects both: every line it fills in the same cycle as a request differs from the requested line. Fills for lines that own no slot are allowed, and they are driven on purpose to show that they have no effect.

// File: rtl/l2mt_pkg.sv
package l2mt_pkg;
  typedef enum logic [2:0] {
    RSP_HIT    = 3'd0,
    RSP_BYPASS = 3'd1,
    RSP_ALLOC  = 3'd2,
    RSP_MERGE  = 3'd3,
    RSP_STALL  = 3'd4
  } rsp_kind_e;
endpackage

// File: rtl/l2mt_cam.sv
// Parallel address compare against every valid slot.
module l2mt_cam #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 26
) (
  input  logic [ENTRIES-1:0] slot_valid,
  input  logic [ADDR_W-1:0]  slot_tag [ENTRIES],
  input  logic [ADDR_W-1:0]  key,
  output logic [ENTRIES-1:0] match
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = slot_valid[g] && (slot_tag[g] == key);
  end
endmodule

// File: rtl/l2mt_free_pick.sv
// Lowest-index free slot finder.
module l2mt_free_pick #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] slot_valid,
  output logic               any_free,
  output logic [IDX_W-1:0]   free_idx
);
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!slot_valid[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/l2mt_occ_counter.sv
// Registered occupancy count and full flag.
module l2mt_occ_counter #(
  parameter int ENTRIES = 16,
  localparam int CNT_W = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count_q,
  output logic             full_q
);
  logic [CNT_W-1:0] count_next;

  always_comb begin
    unique case ({inc, dec})
      2'b10:   count_next = count_q + CNT_W'(1);
      2'b01:   count_next = count_q - CNT_W'(1);
      default: count_next = count_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      full_q  <= 1'b0;
    end else begin
      count_q <= count_next;
      full_q  <= (count_next == CNT_W'(ENTRIES));
    end
  end
endmodule

// File: rtl/l2_miss_tracker.sv
module l2_miss_tracker
  import l2mt_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 26,
  localparam int CNT_W = $clog2(ENTRIES + 1),
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_hit,
  input  logic              req_pf,
  input  logic              req_pf_l3,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  output logic              rsp_valid,
  output logic [2:0]        rsp_kind,
  output logic [CNT_W-1:0]  occupancy,
  output logic              full,
  output logic              fill_ack_valid,
  output logic              fill_ack_hit,
  output logic              fill_ack_pf
);
  // slot storage
  logic [ENTRIES-1:0] slot_valid;
  logic [ENTRIES-1:0] slot_pf;
  logic [ADDR_W-1:0]  slot_tag [ENTRIES];

  logic [ENTRIES-1:0] req_match;
  logic [ENTRIES-1:0] fill_match;
  logic               any_free;
  logic [IDX_W-1:0]   free_idx;

  l2mt_cam #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_req_cam (
    .slot_valid(slot_valid), .slot_tag(slot_tag), .key(req_addr), .match(req_match)
  );

  l2mt_cam #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_fill_cam (
    .slot_valid(slot_valid), .slot_tag(slot_tag), .key(fill_addr), .match(fill_match)
  );

  l2mt_free_pick #(.ENTRIES(ENTRIES)) u_pick (
    .slot_valid(slot_valid), .any_free(any_free), .free_idx(free_idx)
  );

  // request classification
  logic needs_slot, do_merge, do_alloc, do_stall, do_release;
  logic [ENTRIES-1:0] rel_vec;
  rsp_kind_e kind_d;

  always_comb begin
    needs_slot = req_valid && !req_hit && !(req_pf && req_pf_l3);
    do_merge   = needs_slot && (|req_match);
    do_alloc   = needs_slot && !do_merge && !full && any_free;
    do_stall   = needs_slot && !do_merge && !do_alloc;
    rel_vec    = fill_valid ? fill_match : '0;
    do_release = |rel_vec;
    if (req_hit)                kind_d = RSP_HIT;
    else if (req_pf && req_pf_l3) kind_d = RSP_BYPASS;
    else if (do_merge)          kind_d = RSP_MERGE;
    else if (do_stall)          kind_d = RSP_STALL;
    else                        kind_d = RSP_ALLOC;
  end

  // slot state update
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_valid <= '0;
      slot_pf    <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (rel_vec[i]) begin
          slot_valid[i] <= 1'b0;
        end
        if (do_merge && !req_pf && req_match[i]) begin
          slot_pf[i] <= 1'b0;
        end
        if (do_alloc && (free_idx == IDX_W'(i))) begin
          slot_valid[i] <= 1'b1;
          slot_pf[i]    <= req_pf;
        end
      end
    end
  end

  // address storage: no reset, single write port
  always_ff @(posedge clk) begin
    if (do_alloc) begin
      slot_tag[free_idx] <= req_addr;
    end
  end

  l2mt_occ_counter #(.ENTRIES(ENTRIES)) u_occ (
    .clk(clk), .rst(rst), .inc(do_alloc), .dec(do_release),
    .count_q(occupancy), .full_q(full)
  );

  // registered responses
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid      <= 1'b0;
      rsp_kind       <= 3'd0;
      fill_ack_valid <= 1'b0;
      fill_ack_hit   <= 1'b0;
      fill_ack_pf    <= 1'b0;
    end else begin
      rsp_valid      <= req_valid;
      rsp_kind       <= req_valid ? 3'(kind_d) : 3'd0;
      fill_ack_valid <= fill_valid;
      fill_ack_hit   <= do_release;
      fill_ack_pf    <= |(rel_vec & slot_pf);
    end
  end
endmodule

// File: rtl/l2mt_checker.sv
module l2mt_checker #(
  parameter int ENTRIES = 16,
  localparam int CNT_W = $clog2(ENTRIES + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_hit,
  input logic             req_pf,
  input logic             req_pf_l3,
  input logic             rsp_valid,
  input logic [2:0]       rsp_kind,
  input logic [CNT_W-1:0] occupancy,
  input logic             full,
  input logic             fill_ack_valid,
  input logic             fill_ack_hit
);
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(occupancy) <= ENTRIES); // R12

  AST_FULL_FLAG: assert property (@(posedge clk) disable iff (rst)
    full == (int'(occupancy) == ENTRIES)); // R12

  AST_HIT_NO_SLOT: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_hit |=> rsp_kind == 3'd0 && int'(occupancy) <= int'($past(occupancy))); // R3

  AST_L3_BYPASS: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_hit && req_pf && req_pf_l3 |=> rsp_kind == 3'd1); // R4

  AST_ALLOC_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_kind == 3'd2 |-> !$past(full)); // R2

  AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_kind == 3'd4 |-> $past(full)); // R7

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    int'(occupancy) <= int'($past(occupancy)) + 1 &&
    int'(occupancy) + 1 >= int'($past(occupancy))); // R10

  AST_FILL_DEC: assert property (@(posedge clk) disable iff (rst)
    fill_ack_valid && fill_ack_hit && !(rsp_valid && rsp_kind == 3'd2)
      |-> int'(occupancy) + 1 == int'($past(occupancy))); // R8
endmodule

bind l2_miss_tracker l2mt_checker #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_hit(req_hit),
  .req_pf(req_pf), .req_pf_l3(req_pf_l3), .rsp_valid(rsp_valid),
  .rsp_kind(rsp_kind), .occupancy(occupancy), .full(full),
  .fill_ack_valid(fill_ack_valid), .fill_ack_hit(fill_ack_hit)
);

// File: tb/l2_miss_tracker_bench.sv
module l2_miss_tracker_bench;
  localparam int N  = 16;
  localparam int AW = 26;
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_hit = 0, req_pf = 0, req_pf_l3 = 0, fill_valid = 0;
  logic [AW-1:0] req_addr = '0, fill_addr = '0;
  logic rsp_valid, full, fill_ack_valid, fill_ack_hit, fill_ack_pf;
  logic [2:0] rsp_kind;
  logic [CW-1:0] occupancy;

  always #4 clk = ~clk; // 125 MHz

  l2_miss_tracker #(.ENTRIES(N), .ADDR_W(AW)) u_l2_miss_tracker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_hit(req_hit), .req_pf(req_pf), .req_pf_l3(req_pf_l3),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .rsp_valid(rsp_valid),
    .rsp_kind(rsp_kind), .occupancy(occupancy), .full(full),
    .fill_ack_valid(fill_ack_valid), .fill_ack_hit(fill_ack_hit),
    .fill_ack_pf(fill_ack_pf)
  );

  typedef struct {
    bit    has_req;
    int    kind;
    bit    has_fill;
    bit    fhit;
    bit    fpf;
    int    occ;
    string tag;
  } item_t;

  item_t q[$];
  int n_checks = 0;
  int n_fail = 0;

  // reference model of slots
  bit          m_valid [N];
  bit          m_pf    [N];
  logic [AW-1:0] m_addr [N];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int model_occ();
    int c = 0;
    for (int i = 0; i < N; i++) c += m_valid[i];
    return c;
  endfunction

  // driver: one cycle of stimulus, pushes its expected outcome
  task automatic step(input bit rv, input logic [AW-1:0] ra, input bit rh,
                      input bit rp, input bit rl3, input bit fv,
                      input logic [AW-1:0] fa, input string tag);
    item_t it;
    int mi, fi, fr;
    bit pre_full;
    @(negedge clk);
    req_valid = rv; req_addr = ra; req_hit = rh; req_pf = rp; req_pf_l3 = rl3;
    fill_valid = fv; fill_addr = fa;
    pre_full = (model_occ() == N);
    mi = -1; fi = -1; fr = -1;
    for (int i = 0; i < N; i++) begin
      if (m_valid[i] && m_addr[i] == ra) mi = i;
      if (m_valid[i] && m_addr[i] == fa) fi = i;
      if (!m_valid[i] && fr < 0) fr = i;
    end
    it.has_req = rv; it.has_fill = fv; it.tag = tag;
    it.kind = 0; it.fhit = 0; it.fpf = 0;
    if (fv && fi >= 0) begin it.fhit = 1; it.fpf = m_pf[fi]; end
    if (rv) begin
      if (rh) it.kind = 0;
      else if (rp && rl3) it.kind = 1;
      else if (mi >= 0) begin it.kind = 3; if (!rp) m_pf[mi] = 0; end
      else if (pre_full) it.kind = 4;
      else begin
        it.kind = 2;
        m_valid[fr] = 1; m_addr[fr] = ra; m_pf[fr] = rp;
      end
    end
    if (fv && fi >= 0) m_valid[fi] = 0;
    it.occ = model_occ();
    q.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(0, '0, 0, 0, 0, 0, '0, tag);
  endtask

  task automatic miss(input logic [AW-1:0] a, input string tag);
    step(1, a, 0, 0, 0, 0, '0, tag);
  endtask

  task automatic fill(input logic [AW-1:0] a, input string tag);
    step(0, '0, 0, 0, 0, 1, a, tag);
  endtask

  // monitor: compares one item per cycle, 2 ns after the edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        check(rsp_valid == it.has_req, it.tag, "rsp_valid", rsp_valid, it.has_req);
        if (it.has_req)
          check(int'(rsp_kind) == it.kind, it.tag, "rsp_kind", rsp_kind, it.kind);
        check(fill_ack_valid == it.has_fill, it.tag, "fill_ack_valid", fill_ack_valid, it.has_fill);
        if (it.has_fill) begin
          check(fill_ack_hit == it.fhit, it.tag, "fill_ack_hit", fill_ack_hit, it.fhit);
          if (it.fhit)
            check(fill_ack_pf == it.fpf, it.tag, "fill_ack_pf", fill_ack_pf, it.fpf);
        end
        check(int'(occupancy) == it.occ, it.tag, "occupancy", occupancy, it.occ);
        check(full == (it.occ == N), "R12", "full", full, it.occ == N);
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_pf[i] = 0; m_addr[i] = '0; end
    repeat (3) @(posedge clk);
    #2;
    check(occupancy == 0 && !full, "R1", "occupancy/full in reset", occupancy, 0);
    check(!rsp_valid && !fill_ack_valid, "R1", "valids in reset", rsp_valid, 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2;
    check(occupancy == 0 && !rsp_valid && !fill_ack_valid, "R1", "after reset", occupancy, 0);

    miss('h100, "R2"); miss('h101, "R2"); miss('h102, "R2");
    step(1, 'h200, 1, 0, 0, 0, '0, "R3");
    step(1, 'h100, 1, 1, 0, 0, '0, "R3");
    step(1, 'h300, 0, 1, 1, 0, '0, "R4");
    step(1, 'h100, 0, 1, 1, 0, '0, "R4");
    step(1, 'h400, 0, 1, 0, 0, '0, "R5");
    step(1, 'h401, 0, 1, 0, 0, '0, "R5");
    miss('h100, "R6");
    step(1, 'h101, 0, 1, 0, 0, '0, "R6");
    miss('h400, "R11");
    fill('h999, "R9");
    fill('h400, "R11");
    fill('h401, "R8");
    fill('h100, "R8");
    fill('h100, "R9");
    for (int i = 0; i < 14; i++) miss(AW'('h500 + i), "R2");
    idle("R12");
    miss('h600, "R7");
    step(1, 'h601, 0, 1, 0, 0, '0, "R7");
    miss('h101, "R7");
    step(1, 'h777, 1, 0, 0, 0, '0, "R7");
    step(1, 'h602, 0, 0, 0, 1, 'h101, "R7");
    step(1, 'h603, 0, 0, 0, 1, 'h102, "R10");
    step(1, 'h604, 0, 1, 0, 1, 'h500, "R10");
    for (int i = 1; i < 14; i++) fill(AW'('h500 + i), "R8");
    fill('h603, "R8");
    fill('h604, "R8");
    idle("R12");
    idle("R12");
    @(posedge clk); #3;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule